// File: doc/BRIEF.md
# Pushbutton Up/Down Step Controller

This block turns two active-low pushbuttons into a 5-bit tap code for a 32-position resistor ladder. A brief press of either button moves the code one position. If the button stays down past a long-press threshold, stepping repeats automatically at a fixed pace for as long as the button is held. The code stops at both ends of its range. When both buttons are down together, the code always moves toward zero.

Each raw button line first passes through a two-flop synchronizer and a debounce filter. A press timer then turns the clean level into single step pulses, each carrying a direction. A position register applies the pulses with saturation and drives a registered one-hot tap-select vector. A preset input picks the value loaded during reset: zero-scale or mid-scale. All timing is set in milliseconds and converted to clock cycles from a `CLK_HZ` parameter. `CLK_HZ` must be a multiple of 1000.

Top module: `pbs_updown_ctrl`

## Requirements
- R1: `code` changes only on a step. Each step moves it by exactly one position, so it never jumps and never wraps between 0 and 31.
- R2: A short press of `up_n` (driven low, then released before the long-press threshold) raises `code` by exactly one.
- R3: A short press of `down_n` lowers `code` by exactly one.
- R4: At 31, further up requests are ignored, even while `up_n` stays low through auto-repeat.
- R5: At 0, further down requests are ignored, even while `down_n` stays low through auto-repeat.
- R6: The first step of a press happens on the debounced press edge. If the press continues, a second step follows `HOLD_MS` (default 1000 ms) later. Further steps follow every `REPEAT_MS` (default 250 ms) until release.
- R7: While `up_n` and `down_n` are both low, every step is a decrement, and `code` saturates at 0.
- R8: During reset, `code` loads 16 when `preset_mid` is 1 and 0 when `preset_mid` is 0. `tap_sel` loads to match.
- R9: A level change on a button input that lasts fewer than `DEBOUNCE_MS` worth of cycles (default 20 ms) is ignored. A press with short bounces at both edges gives one step.
- R10: `tap_sel` is one-hot, with bit `code` set. It changes in the same cycle as `code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| up_n | input | 1 | Up pushbutton, active low, asynchronous |
| down_n | input | 1 | Down pushbutton, active low, asynchronous |
| preset_mid | input | 1 | Reset value select: 1 gives mid-scale (16), 0 gives zero-scale |
| code | output | 5 | Current tap position, 0 to 31 |
| tap_sel | output | 32 | One-hot decode of `code` |

## Verification
Short presses of assorted lengths are swept upward from 0 past 31, then downward past 0. This checks every single-step transition and both saturation ends. Held presses are timed just short of, and just past, the long-press mark and each repeat mark. This tells a correct repeat schedule apart from an early or late one. Presses of both buttons together, started both low and high in the range, confirm that down always wins. Bare glitches and bouncy presses separate a working filter from one that passes bounce through as extra steps.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_RPT  = 2'd2
  } pbs_state_e;

  localparam int unsigned NUM_BTN = 2;
  localparam int unsigned BTN_UP  = 0;
  localparam int unsigned BTN_DN  = 1;

  function automatic int unsigned ms_cycles(input int unsigned hz, input int unsigned ms);
    return (hz / 1000) * ms;
  endfunction
endpackage

// File: rtl/pbs_debounce.sv
module pbs_debounce #(
  parameter int unsigned CYC = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_n,
  output logic pressed
);
  localparam int unsigned CW = $clog2(CYC + 1);

  logic          sync1_n, sync2_n, stable_n;
  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1_n  <= 1'b1;
      sync2_n  <= 1'b1;
      stable_n <= 1'b1;
      run_cnt  <= '0;
    end else begin
      sync1_n <= raw_n;
      sync2_n <= sync1_n;
      if (sync2_n == stable_n) begin
        run_cnt <= '0;
      end else if (run_cnt == CW'(CYC - 1)) begin
        stable_n <= sync2_n;
        run_cnt  <= '0;
      end else begin
        run_cnt <= run_cnt + CW'(1);
      end
    end
  end

  assign pressed = ~stable_n;
endmodule

// File: rtl/pbs_step_timer.sv
module pbs_step_timer
  import pbs_pkg::*;
#(
  parameter int unsigned HOLD_CYC = 1000,
  parameter int unsigned REP_CYC  = 250
) (
  input  logic clk,
  input  logic rst,
  input  logic up_p,
  input  logic dn_p,
  output logic step,
  output logic dir_down
);
  localparam int unsigned MAXC = (HOLD_CYC > REP_CYC) ? HOLD_CYC : REP_CYC;
  localparam int unsigned TW   = $clog2(MAXC + 1);

  pbs_state_e    state;
  logic [TW-1:0] tcnt;
  logic          any_p;

  assign any_p = up_p | dn_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      tcnt     <= '0;
      step     <= 1'b0;
      dir_down <= 1'b0;
    end else begin
      step     <= 1'b0;
      dir_down <= dn_p;
      case (state)
        ST_IDLE: begin
          if (any_p) begin
            step  <= 1'b1;
            tcnt  <= TW'(1);
            state <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (!any_p) begin
            state <= ST_IDLE;
          end else if (tcnt == TW'(HOLD_CYC)) begin
            step  <= 1'b1;
            tcnt  <= TW'(1);
            state <= ST_RPT;
          end else begin
            tcnt <= tcnt + TW'(1);
          end
        end
        ST_RPT: begin
          if (!any_p) begin
            state <= ST_IDLE;
          end else if (tcnt == TW'(REP_CYC)) begin
            step <= 1'b1;
            tcnt <= TW'(1);
          end else begin
            tcnt <= tcnt + TW'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pbs_wiper_pos.sv
module pbs_wiper_pos #(
  parameter int unsigned CODE_W = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   preset_mid,
  input  logic                   step,
  input  logic                   dir_down,
  output logic [CODE_W-1:0]      code,
  output logic [(1<<CODE_W)-1:0] tap_sel
);
  localparam int unsigned TAPS = 1 << CODE_W;
  localparam logic [CODE_W-1:0] TOP = CODE_W'(TAPS - 1);
  localparam logic [CODE_W-1:0] MID = CODE_W'(TAPS / 2);

  logic [CODE_W-1:0] nxt;

  always_comb begin
    nxt = code;
    if (step) begin
      if (dir_down) begin
        if (code != '0) nxt = code - CODE_W'(1);
      end else begin
        if (code != TOP) nxt = code + CODE_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code    <= preset_mid ? MID : '0;
      tap_sel <= preset_mid ? ({{(TAPS-1){1'b0}}, 1'b1} << MID) : {{(TAPS-1){1'b0}}, 1'b1};
    end else begin
      code    <= nxt;
      tap_sel <= {{(TAPS-1){1'b0}}, 1'b1} << nxt;
    end
  end
endmodule

// File: rtl/pbs_updown_ctrl.sv
module pbs_updown_ctrl
  import pbs_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 1_000_000,
  parameter int unsigned DEBOUNCE_MS = 20,
  parameter int unsigned HOLD_MS     = 1000,
  parameter int unsigned REPEAT_MS   = 250,
  parameter int unsigned CODE_W      = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   up_n,
  input  logic                   down_n,
  input  logic                   preset_mid,
  output logic [CODE_W-1:0]      code,
  output logic [(1<<CODE_W)-1:0] tap_sel
);
  localparam int unsigned DB_CYC   = ms_cycles(CLK_HZ, DEBOUNCE_MS);
  localparam int unsigned HOLD_CYC = ms_cycles(CLK_HZ, HOLD_MS);
  localparam int unsigned REP_CYC  = ms_cycles(CLK_HZ, REPEAT_MS);

  logic [NUM_BTN-1:0] raw_n;
  logic [NUM_BTN-1:0] btn_p;
  logic               step_w;
  logic               dir_w;

  assign raw_n[BTN_UP] = up_n;
  assign raw_n[BTN_DN] = down_n;

  for (genvar b = 0; b < NUM_BTN; b++) begin : g_btn
    pbs_debounce #(.CYC(DB_CYC)) u_db (
      .clk    (clk),
      .rst    (rst),
      .raw_n  (raw_n[b]),
      .pressed(btn_p[b])
    );
  end

  pbs_step_timer #(.HOLD_CYC(HOLD_CYC), .REP_CYC(REP_CYC)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .up_p    (btn_p[BTN_UP]),
    .dn_p    (btn_p[BTN_DN]),
    .step    (step_w),
    .dir_down(dir_w)
  );

  pbs_wiper_pos #(.CODE_W(CODE_W)) u_pos (
    .clk       (clk),
    .rst       (rst),
    .preset_mid(preset_mid),
    .step      (step_w),
    .dir_down  (dir_w),
    .code      (code),
    .tap_sel   (tap_sel)
  );
endmodule

// File: rtl/pbs_updown_chk.sv
module pbs_updown_chk #(
  parameter int unsigned CODE_W = 5
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   preset_mid,
  input logic                   step,
  input logic [CODE_W-1:0]      code,
  input logic [(1<<CODE_W)-1:0] tap_sel
);
  localparam logic [CODE_W-1:0] TOP = CODE_W'((1 << CODE_W) - 1);
  localparam logic [CODE_W-1:0] MID = CODE_W'((1 << CODE_W) / 2);

  // R1: a move is always one position
  p_unit_move_r1: assert property (@(posedge clk) disable iff (rst)
    (code != $past(code)) |-> (code == $past(code) + CODE_W'(1) || code == $past(code) - CODE_W'(1)));

  // R1: no change without a preceding step pulse
  p_no_idle_move_r1: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(code));

  // R4: full scale never wraps to zero
  p_top_no_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (code == TOP) |=> (code != '0));

  // R5: zero scale never wraps to full
  p_zero_no_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (code == '0) |=> (code != TOP));

  // R6: step pulses are isolated single cycles
  p_step_gap_r6: assert property (@(posedge clk) disable iff (rst)
    step |=> !step);

  // R8: value right after reset follows preset select
  p_preset_r8: assert property (@(posedge clk)
    $fell(rst) |-> (code == (preset_mid ? MID : '0)));

  // R10: decode is one-hot at the code position
  p_onehot_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot(tap_sel) && tap_sel[code]);
endmodule

bind pbs_updown_ctrl pbs_updown_chk #(.CODE_W(CODE_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .preset_mid(preset_mid),
  .step      (step_w),
  .code      (code),
  .tap_sel   (tap_sel)
);

// File: tb/pbs_updown_ctrl_tb_top.sv
`timescale 1ns/1ps
module pbs_updown_ctrl_tb_top;
  localparam int unsigned CLK_HZ = 1000;
  localparam int DB     = 20;
  localparam int HOLD   = 1000;
  localparam int REP    = 250;
  localparam int SETTLE = 60;
  localparam int WD     = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        up_n = 1'b1;
  logic        down_n = 1'b1;
  logic        preset_mid = 1'b0;
  logic [4:0]  code;
  logic [31:0] tap_sel;

  int checks = 0;
  int errors = 0;
  int ref_code = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pbs_updown_ctrl #(.CLK_HZ(CLK_HZ)) dut_i (
    .clk(clk), .rst(rst), .up_n(up_n), .down_n(down_n),
    .preset_mid(preset_mid), .code(code), .tap_sel(tap_sel)
  );

  task automatic check(input string req);
    checks++;
    if (code !== 5'(ref_code)) begin
      errors++;
      $display("FAIL %s code actual=%0d expected=%0d", req, code, ref_code);
    end
    checks++;
    if (tap_sel !== (32'd1 << ref_code)) begin
      errors++;
      $display("FAIL R10 (%s) tap_sel actual=%h expected=%h", req, tap_sel, 32'd1 << ref_code);
    end
  endtask

  task automatic apply_reset(input logic pm);
    @(negedge clk);
    preset_mid = pm;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    ref_code = pm ? 16 : 0;
  endtask

  function automatic int steps_for(input int dur);
    if (dur - 1 >= HOLD) return 2 + (dur - 1 - HOLD) / REP;
    return 1;
  endfunction

  task automatic press(input bit u, input bit d, input int dur);
    int n;
    @(negedge clk);
    up_n = !u;
    down_n = !d;
    repeat (dur) @(negedge clk);
    up_n = 1'b1;
    down_n = 1'b1;
    repeat (SETTLE) @(negedge clk);
    n = steps_for(dur);
    for (int i = 0; i < n; i++) begin
      if (d) begin
        if (ref_code > 0) ref_code--;
      end else begin
        if (ref_code < 31) ref_code++;
      end
    end
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R8: zero-scale preset
    apply_reset(1'b0);
    check("R8");
    // R2, R4: short-press sweep upward, past full scale
    for (int i = 0; i < 34; i++) begin
      press(1'b1, 1'b0, 30 + (i * 7) % 200);
      check(i < 31 ? "R2" : "R4");
    end
    // R3, R5: short-press sweep downward, past zero
    for (int i = 0; i < 34; i++) begin
      press(1'b0, 1'b1, 25 + (i * 11) % 300);
      check(i < 31 ? "R3" : "R5");
    end
    // R8: mid-scale preset
    apply_reset(1'b1);
    check("R8");
    // R6: hold just short of and just past each timing mark
    press(1'b1, 1'b0, HOLD - 50);           check("R6");
    press(1'b1, 1'b0, HOLD + 50);           check("R6");
    press(1'b1, 1'b0, HOLD + REP - 50);     check("R6");
    press(1'b1, 1'b0, HOLD + REP + 50);     check("R6");
    press(1'b0, 1'b1, HOLD + 3 * REP + 50); check("R6");
    // R4: long hold up to full scale, stays there
    press(1'b1, 1'b0, HOLD + 20 * REP + 50); check("R4");
    // R7: both held, decrements from top
    press(1'b1, 1'b1, HOLD + 2 * REP + 50);  check("R7");
    // R7, R5: both held long, reaches zero and holds
    press(1'b1, 1'b1, HOLD + 30 * REP + 50); check("R7");
    // R9: bare glitches shorter than the debounce window
    press(1'b1, 1'b0, 10);
    press(1'b1, 1'b0, 15);
    press(1'b1, 1'b0, 10); // up from 0 here: model applies nothing below
    ref_code = 0;
    check("R9");
    // R9: bouncy up press yields one step
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); up_n = 1'b0;
      repeat (3 + i) @(negedge clk); up_n = 1'b1;
      repeat (4) @(negedge clk);
    end
    up_n = 1'b0;
    repeat (80) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      up_n = 1'b1; repeat (4) @(negedge clk);
      up_n = 1'b0; repeat (3) @(negedge clk);
    end
    up_n = 1'b1;
    repeat (SETTLE) @(negedge clk);
    ref_code = 1;
    check("R9");
    // R2: one more clean press after the bounce test
    press(1'b1, 1'b0, 40); check("R2");
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule